// File: doc/BRIEF.md
# Interrupt Source Configuration Unit

This unit is the per-source front end of an interrupt controller. Each external request line is passed through a synchroniser, converted to an internal "asserted" level using a programmable polarity, and detected either as an edge or as a level. Each source keeps a pending flag and an in-service flag. It presents a request, together with its programmed priority, vector and processor destination mask, to a downstream delivery block. That block answers with per-source acknowledge and end-of-interrupt strobes.

Software reaches each source through two 32-bit registers on a flat register bus. Address bit 0 selects the register: 0 for the configuration register, 1 for the destination register. The upper address bits select the source. A write carries a per-bit write mask, so a single field can be updated without disturbing its neighbours.

A read-only busy bit reports whether the source is in flight. Software can mask a source and then poll the busy bit until it reads 0 before changing the source's vector or priority safely.

Top module: `isc_bank`

## Requirements
- R1: After reset every configuration register reads 0x8000_0000 (masked, all other fields 0), every destination register reads 0, and no source requests.
- R2: Configuration register layout: bit 31 mask, bit 30 busy (read-only), bit 23 polarity, bit 22 sense, bits 16 and up priority (PRIO_W bits), bits 0 and up vector (VEC_W bits). Other bits read 0. A write changes only the bits set in `bus_wmask`, and the busy bit ignores writes.
- R3: The destination register holds NUM_CPU bits in its low bits, with the upper bits reading 0. It is presented on that source's slice of `src_dest`.
- R4: The priority and vector fields are presented on that source's slices of `src_prio` and `src_vec`.
- R5: With sense 0 (edge), polarity 1 latches a request on a rising input edge and polarity 0 on a falling edge. The opposite edge latches nothing.
- R6: With sense 1 (level), the source requests while its input sits at the asserted level (high for polarity 1, low for polarity 0). If the input is still asserted after end-of-interrupt, the source requests again.
- R7: While the mask bit is 1 or the priority is 0, the source raises no request. An edge that arrives during that time is not remembered once the source is enabled again.
- R8: An acknowledge while requesting clears an edge source's pending flag and places the source in service. While in service there is no request. An edge that arrives during service is delivered after end-of-interrupt.
- R9: The busy bit reads 1 while the source is pending or in service. It returns to 0 after end-of-interrupt when nothing new is pending, or after masking when the source is not in service.
- R10: An acknowledge to a source that is not requesting, and an end-of-interrupt to a source that is not in service, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | Raw asynchronous interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | IDX_W+1 | Source index in the upper bits; bit 0 selects the destination register |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_req | output | NUM_SRC | Request per source |
| src_prio | output | NUM_SRC*PRIO_W | Priority per source |
| src_vec | output | NUM_SRC*VEC_W | Vector per source |
| src_dest | output | NUM_SRC*NUM_CPU | Destination mask per source |
| src_ack | input | NUM_SRC | Acknowledge strobe per source |
| src_eoi | input | NUM_SRC | End-of-interrupt strobe per source |

## Verification
Random partial-mask writes are checked field by field against a bench model. A design that merged the wrong bits would corrupt a neighbouring field, and one that let the busy bit be written would show it set while idle. Directed sequences go after the edge cases:
- an edge arriving during service, which a wrong design drops or delivers early;
- an edge seen while masked or at priority 0, which a wrong design remembers and fires on unmask;
- the opposite edge, or a polarity change with the input held, which a wrong design turns into a false request;
- stray acknowledge or end-of-interrupt strobes, which a wrong design lets put an idle source into service or drop a pending one.

The level source is also checked for re-request after end-of-interrupt while its input stays asserted.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int unsigned REG_W     = 32;
   localparam int unsigned MASK_BIT  = 31;
   localparam int unsigned BUSY_BIT  = 30;
   localparam int unsigned POL_BIT   = 23;
   localparam int unsigned SENSE_BIT = 22;
   localparam int unsigned PRIO_LSB  = 16;
   localparam int unsigned PRIO_MAXW = SENSE_BIT - PRIO_LSB;
   localparam int unsigned VEC_MAXW  = PRIO_LSB;

   typedef enum logic {
      DET_EDGE  = 1'b0,
      DET_LEVEL = 1'b1
   } det_mode_e;

   function automatic logic [REG_W-1:0] merge_bits(input logic [REG_W-1:0] old_v,
                                                   input logic [REG_W-1:0] new_v,
                                                   input logic [REG_W-1:0] en_v);
      return (old_v & ~en_v) | (new_v & en_v);
   endfunction
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/isc_cfg_reg.sv
module isc_cfg_reg
   import isc_pkg::*;
#(
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned NUM_CPU = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_cfg,
   input  logic               wr_dst,
   input  logic [REG_W-1:0]   wdata,
   input  logic [REG_W-1:0]   wmask,
   output logic               mask_o,
   output logic               pol_o,
   output det_mode_e          mode_o,
   output logic [PRIO_W-1:0]  prio_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic [NUM_CPU-1:0] dest_o,
   output logic [REG_W-1:0]   cfg_img,
   output logic [REG_W-1:0]   dst_img
);
   logic               mask_q, pol_q;
   det_mode_e          mode_q;
   logic [PRIO_W-1:0]  prio_q;
   logic [VEC_W-1:0]   vec_q;
   logic [NUM_CPU-1:0] dest_q;
   logic [REG_W-1:0]   cfg_nxt, dst_nxt;
   logic               unused_nxt;

   always_comb begin
      cfg_img                    = '0;
      cfg_img[MASK_BIT]          = mask_q;
      cfg_img[POL_BIT]           = pol_q;
      cfg_img[SENSE_BIT]         = mode_q;
      cfg_img[PRIO_LSB +: PRIO_W] = prio_q;
      cfg_img[VEC_W-1:0]         = vec_q;
   end

   assign dst_img    = REG_W'(dest_q);
   assign cfg_nxt    = merge_bits(cfg_img, wdata, wmask);
   assign dst_nxt    = merge_bits(dst_img, wdata, wmask);
   assign unused_nxt = ^{cfg_nxt, dst_nxt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
         pol_q  <= 1'b0;
         mode_q <= DET_EDGE;
         prio_q <= '0;
         vec_q  <= '0;
         dest_q <= '0;
      end else begin
         if (wr_cfg) begin
            mask_q <= cfg_nxt[MASK_BIT];
            pol_q  <= cfg_nxt[POL_BIT];
            mode_q <= det_mode_e'(cfg_nxt[SENSE_BIT]);
            prio_q <= cfg_nxt[PRIO_LSB +: PRIO_W];
            vec_q  <= cfg_nxt[VEC_W-1:0];
         end
         if (wr_dst) dest_q <= dst_nxt[NUM_CPU-1:0];
      end
   end

   assign mask_o = mask_q;
   assign pol_o  = pol_q;
   assign mode_o = mode_q;
   assign prio_o = prio_q;
   assign vec_o  = vec_q;
   assign dest_o = dest_q;

   // R2: a write that does not enable the priority bits leaves priority alone
   assert_prio_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cfg && (wmask[PRIO_LSB +: PRIO_W] == '0)) |=> $stable(prio_q));
   // R2: a write that does not enable the vector bits leaves the vector alone
   assert_vec_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cfg && (wmask[VEC_W-1:0] == '0)) |=> $stable(vec_q));
endmodule

// File: rtl/isc_capture.sv
module isc_capture
   import isc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      line_sync,
   input  logic      mask,
   input  logic      prio_nz,
   input  logic      pol,
   input  det_mode_e mode,
   input  logic      ack,
   input  logic      eoi,
   output logic      req,
   output logic      busy
);
   logic asserted, asserted_q, rise, enabled, take;
   logic pend_q, pend_d, svc_q, svc_d;

   assign asserted = pol ? line_sync : ~line_sync;
   assign rise     = asserted & ~asserted_q;
   assign enabled  = ~mask & prio_nz;
   assign req      = pend_q & ~svc_q & enabled;
   assign take     = req & ack;
   assign busy     = pend_q | svc_q;

   always_comb begin
      if (!enabled)                pend_d = 1'b0;
      else if (mode == DET_LEVEL)  pend_d = asserted;
      else if (take)               pend_d = rise;
      else                         pend_d = pend_q | rise;
   end

   always_comb begin
      if (take)      svc_d = 1'b1;
      else if (eoi)  svc_d = 1'b0;
      else           svc_d = svc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asserted_q <= 1'b0;
         pend_q     <= 1'b0;
         svc_q      <= 1'b0;
      end else begin
         asserted_q <= asserted;
         pend_q     <= pend_d;
         svc_q      <= svc_d;
      end
   end

   // R8: an accepted acknowledge withdraws the request on the next cycle
   assert_ack_withdraws_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack) |=> !req);
   // R9: a request is always reflected in the busy flag
   assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> busy);
   // R9: end-of-interrupt without a fresh acknowledge leaves service
   assert_eoi_leaves_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack) |=> !svc_q);
   // R7: a source masked for two cycles holds nothing pending
   assert_masked_no_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && $past(mask)) |-> !pend_q);
endmodule

// File: rtl/isc_bank.sv
module isc_bank
   import isc_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 4,
   parameter int unsigned NUM_CPU     = 4,
   parameter int unsigned PRIO_W      = 4,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int unsigned ADDR_W     = IDX_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         irq_in,
   input  logic                       bus_wr,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [REG_W-1:0]           bus_wdata,
   input  logic [REG_W-1:0]           bus_wmask,
   output logic [REG_W-1:0]           bus_rdata,
   output logic [NUM_SRC-1:0]         src_req,
   output logic [NUM_SRC*PRIO_W-1:0]  src_prio,
   output logic [NUM_SRC*VEC_W-1:0]   src_vec,
   output logic [NUM_SRC*NUM_CPU-1:0] src_dest,
   input  logic [NUM_SRC-1:0]         src_ack,
   input  logic [NUM_SRC-1:0]         src_eoi
);
   if (NUM_SRC < 1) begin : g_bad_src
      $error("isc_bank: NUM_SRC must be at least 1");
   end
   if (NUM_CPU < 1 || NUM_CPU > REG_W) begin : g_bad_cpu
      $error("isc_bank: NUM_CPU must be 1..32");
   end
   if (PRIO_W < 1 || PRIO_W > PRIO_MAXW) begin : g_bad_prio
      $error("isc_bank: PRIO_W out of range");
   end
   if (VEC_W < 1 || VEC_W > VEC_MAXW) begin : g_bad_vec
      $error("isc_bank: VEC_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("isc_bank: SYNC_STAGES must be at least 2");
   end

   logic [IDX_W-1:0]  sel_idx;
   logic              sel_dst;
   logic [REG_W-1:0]  cfg_img [NUM_SRC];
   logic [REG_W-1:0]  dst_img [NUM_SRC];
   logic [NUM_SRC-1:0] busy;

   assign sel_idx = bus_addr[ADDR_W-1:1];
   assign sel_dst = bus_addr[0];

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic              hit, line_sync, mask, pol;
      det_mode_e         mode;
      logic [PRIO_W-1:0] prio;

      assign hit = bus_wr && (int'(sel_idx) == g);

      isc_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk (clk), .rst_n (rst_n), .din (irq_in[g]), .dout (line_sync)
      );

      isc_cfg_reg #(.PRIO_W(PRIO_W), .VEC_W(VEC_W), .NUM_CPU(NUM_CPU)) u_cfg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_cfg  (hit && !sel_dst),
         .wr_dst  (hit && sel_dst),
         .wdata   (bus_wdata),
         .wmask   (bus_wmask),
         .mask_o  (mask),
         .pol_o   (pol),
         .mode_o  (mode),
         .prio_o  (prio),
         .vec_o   (src_vec[g*VEC_W +: VEC_W]),
         .dest_o  (src_dest[g*NUM_CPU +: NUM_CPU]),
         .cfg_img (cfg_img[g]),
         .dst_img (dst_img[g])
      );

      assign src_prio[g*PRIO_W +: PRIO_W] = prio;

      isc_capture u_cap (
         .clk       (clk),
         .rst_n     (rst_n),
         .line_sync (line_sync),
         .mask      (mask),
         .prio_nz   (prio != '0),
         .pol       (pol),
         .mode      (mode),
         .ack       (src_ack[g]),
         .eoi       (src_eoi[g]),
         .req       (src_req[g]),
         .busy      (busy[g])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (int'(sel_idx) == i) begin
            if (sel_dst) bus_rdata = dst_img[i];
            else         bus_rdata = cfg_img[i] | (REG_W'(busy[i]) << BUSY_BIT);
         end
      end
   end

   // R7: a source whose priority field is zero never requests
   assert_prio0_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_prio[PRIO_W-1:0] == '0) |-> !src_req[0]);
endmodule

// File: tb/isc_bank_tb_top.sv
`timescale 1ns/1ps
module isc_bank_tb_top;
   localparam int NS = 4, NC = 4, PW = 4, VW = 8;
   localparam logic [31:0] CFG_WR = 32'h80C0_0000 | (32'((1 << PW) - 1) << 16) | 32'((1 << VW) - 1);
   localparam logic [31:0] DST_WR = 32'((1 << NC) - 1);
   localparam logic [31:0] BUSY   = 32'h4000_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NS-1:0] irq_in = '0, src_ack = '0, src_eoi = '0;
   logic bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_wmask = '0, bus_rdata;
   logic [NS-1:0] src_req;
   logic [NS*PW-1:0] src_prio;
   logic [NS*VW-1:0] src_vec;
   logic [NS*NC-1:0] src_dest;

   int total = 0, bad = 0;
   bit done = 0;
   logic [31:0] m_cfg [NS];
   logic [31:0] m_dst [NS];

   always #2.5 clk = ~clk;

   isc_bank #(.NUM_SRC(NS), .NUM_CPU(NC), .PRIO_W(PW), .VEC_W(VW)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
      .src_req(src_req), .src_prio(src_prio), .src_vec(src_vec), .src_dest(src_dest),
      .src_ack(src_ack), .src_eoi(src_eoi));

   function automatic logic [31:0] upd(logic [31:0] o, logic [31:0] d, logic [31:0] m, logic [31:0] w);
      return (o & ~(m & w)) | (d & m & w);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; irq_in = '0;
      wait_n(2); rst_n = 1'b1; wait_n(1);
      for (int i = 0; i < NS; i++) begin m_cfg[i] = 32'h8000_0000; m_dst[i] = '0; end
   endtask

   task automatic wr(int idx, bit dst, logic [31:0] d, logic [31:0] m);
      @(negedge clk);
      bus_addr = {2'(idx), dst}; bus_wdata = d; bus_wmask = m; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      if (dst) m_dst[idx] = upd(m_dst[idx], d, m, DST_WR);
      else     m_cfg[idx] = upd(m_cfg[idx], d, m, CFG_WR);
      #1;
   endtask

   task automatic rd(int idx, bit dst, output logic [31:0] d);
      @(negedge clk); bus_addr = {2'(idx), dst}; #1; d = bus_rdata;
   endtask

   task automatic pulse(int idx, bit is_eoi);
      @(negedge clk);
      if (is_eoi) src_eoi[idx] = 1'b1; else src_ack[idx] = 1'b1;
      @(negedge clk); src_eoi = '0; src_ack = '0; #1;
   endtask

   task automatic chk_busy(string tag, int idx, bit exp);
      logic [31:0] d;
      rd(idx, 0, d);
      check(tag, 32'(d[30]), 32'(exp));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      do_reset();
      // R1: reset values
      for (int i = 0; i < NS; i++) begin
         rd(i, 0, d); check("R1 cfg reset", d, 32'h8000_0000);
         rd(i, 1, d); check("R1 dst reset", d, 32'h0);
      end
      check("R1 no request", 32'(src_req), 32'h0);

      // R3: destination width and output
      wr(2, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(2, 1, d); check("R3 dst readback", d, 32'h0000_000F);
      check("R3 dst out", 32'(src_dest[2*NC +: NC]), 32'hF);

      // R2: full write, busy bit ignored, then priority-only write
      wr(2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(2, 0, d); check("R2 full write", d, 32'h80CF_00FF);
      wr(2, 0, 32'h0003_0000, 32'h000F_0000);
      rd(2, 0, d); check("R2 prio only", d, 32'h80C3_00FF);
      wr(2, 0, 32'h0000_0000, 32'h8000_0000);
      rd(2, 0, d); check("R2 unmask only", d, 32'h00C3_00FF);
      check("R4 prio out", 32'(src_prio[2*PW +: PW]), 32'h3);
      check("R4 vec out", 32'(src_vec[2*VW +: VW]), 32'hFF);
      wr(2, 0, 32'h8000_0000, 32'h8000_0000);

      // R5/R8/R9: edge source 0, rising
      wr(0, 0, 32'h0085_0021, 32'hFFFF_FFFF);
      wr(0, 1, 32'h0000_0005, 32'hFFFF_FFFF);
      check("R4 vec0", 32'(src_vec[VW-1:0]), 32'h21);
      check("R4 prio0", 32'(src_prio[PW-1:0]), 32'h5);
      check("R3 dest0", 32'(src_dest[NC-1:0]), 32'h5);
      wait_n(4); check("R5 idle no req", 32'(src_req[0]), 0);
      irq_in[0] = 1'b1; wait_n(4);
      check("R5 rising req", 32'(src_req[0]), 1);
      chk_busy("R9 busy pending", 0, 1);
      pulse(0, 0);
      check("R8 ack drops req", 32'(src_req[0]), 0);
      chk_busy("R9 busy in service", 0, 1);
      irq_in[0] = 1'b0; wait_n(4); irq_in[0] = 1'b1; wait_n(4);
      check("R8 held in service", 32'(src_req[0]), 0);
      pulse(0, 1);
      check("R8 edge after eoi", 32'(src_req[0]), 1);
      pulse(0, 0); pulse(0, 1);
      check("R8 no req after eoi", 32'(src_req[0]), 0);
      chk_busy("R9 idle after eoi", 0, 0);

      // R5: falling edge with polarity 0
      wr(0, 0, 32'h0, 32'h0080_0000); wait_n(4);
      check("R5 pol change no req", 32'(src_req[0]), 0);
      irq_in[0] = 1'b0; wait_n(4);
      check("R5 falling req", 32'(src_req[0]), 1);
      pulse(0, 0); pulse(0, 1);
      irq_in[0] = 1'b1; wait_n(4);
      check("R5 rising ignored pol0", 32'(src_req[0]), 0);

      // R10: stray strobes
      pulse(0, 0); pulse(0, 1);
      chk_busy("R10 stray ack idle", 0, 0);
      irq_in[0] = 1'b0; wait_n(4);
      check("R10 req after stray ack", 32'(src_req[0]), 1);
      pulse(0, 1);
      check("R10 stray eoi keeps req", 32'(src_req[0]), 1);
      pulse(0, 0); pulse(0, 1);

      // R7: mask and priority zero
      wr(0, 0, 32'h0080_0000, 32'h0080_0000);
      wr(0, 0, 32'h8000_0000, 32'h8000_0000);
      irq_in[0] = 1'b1; wait_n(4);
      check("R7 masked no req", 32'(src_req[0]), 0);
      wr(0, 0, 32'h0, 32'h8000_0000); wait_n(4);
      check("R7 edge not remembered", 32'(src_req[0]), 0);
      chk_busy("R7 busy clear", 0, 0);
      irq_in[0] = 1'b0; wait_n(4);
      wr(0, 0, 32'h0, 32'h000F_0000);
      irq_in[0] = 1'b1; wait_n(4);
      check("R7 prio zero no req", 32'(src_req[0]), 0);

      // R6: level source 1
      wr(1, 0, 32'h00C9_0040, 32'hFFFF_FFFF);
      wait_n(4); check("R6 level idle", 32'(src_req[1]), 0);
      irq_in[1] = 1'b1; wait_n(4);
      check("R6 level req", 32'(src_req[1]), 1);
      pulse(1, 0); check("R6 ack holds off", 32'(src_req[1]), 0);
      pulse(1, 1); check("R6 re-request", 32'(src_req[1]), 1);
      pulse(1, 0); irq_in[1] = 1'b0; wait_n(4);
      pulse(1, 1);
      check("R6 level released", 32'(src_req[1]), 0);
      chk_busy("R9 level idle", 1, 0);
      wr(1, 0, 32'h0, 32'h0080_0000); wait_n(4);
      check("R6 active-low req", 32'(src_req[1]), 1);
      wr(1, 0, 32'h8000_0000, 32'h8000_0000);
      check("R7 mask drops req", 32'(src_req[1]), 0);
      wait_n(1);
      chk_busy("R9 busy clears on mask", 1, 0);

      // R2/R3/R4: random partial writes against the model
      do_reset();
      for (int k = 0; k < 150; k++) begin
         int idx;
         bit dst;
         logic [31:0] dv, mv;
         idx = int'($urandom % NS);
         dst = 1'($urandom % 2);
         dv = $urandom;
         mv = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
         wr(idx, dst, dv, mv);
         rd(idx, dst, d);
         if (dst) begin
            check("R3 random dst", d, m_dst[idx]);
            check("R3 random dest out", 32'(src_dest[idx*NC +: NC]), m_dst[idx]);
         end else begin
            check("R2 random cfg", d & ~BUSY, m_cfg[idx]);
            check("R4 random prio", 32'(src_prio[idx*PW +: PW]), (m_cfg[idx] >> 16) & 32'hF);
            check("R4 random vec", 32'(src_vec[idx*VW +: VW]), m_cfg[idx] & 32'hFF);
         end
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule